// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block lets a bus running on a fast clock write registers that live in a slow low-power domain clocked at about 32.768 kHz. A write to any address other than the local status and interrupt-enable words is latched, carried across the boundary with a toggle request/acknowledge handshake, and presented once on the slow-domain commit port. The hold register keeps the address and data stable until the acknowledge returns.

Four flags in the status word report progress. Busy means a transfer is in flight. Next means another write can be accepted. Complete means the last transfer has committed. Error means a write arrived while one was still in flight, and that write was dropped. The complete flag clears when the status word is read. The error flag clears only when software writes 1 to it. The interrupt-enable word is updated at bus speed and is never synchronized. An interrupt output combines the flags with their enables.

Top module: `slow_reg_write_sync`

## Requirements
- R1: After reset the status word (word index 0) reads 0x200, which is only the next flag at bit 9. The enable word (word index 1) reads 0, and irq_o is low.
- R2: A write to any word index other than 0 or 1, made while not busy, appears on the slow side as exactly one commit_valid_o pulse. That pulse carries the same address and data and arrives within four slow clock cycles of acceptance.
- R3: The busy flag (status bit 10) is set from the cycle after acceptance until the acknowledge returns. The next flag (bit 9) is its inverse.
- R4: The complete flag (bit 8) is set in the same cycle that busy clears.
- R5: A status read returns the value before the read and then clears the complete flag. If a completion lands in the same cycle as the read, the flag stays set.
- R6: A synchronized write issued while busy sets the error flag (bit 7) and is dropped. It produces no commit.
- R7: The error flag is cleared only by writing the status word with bit 7 set. Reads do not clear it, and status writes with bit 7 clear leave it unchanged. Status writes are local and never synchronized.
- R8: Writes to the enable word (bits 9..7) take effect on the next cycle. They never set busy, complete or error, and never produce a commit, even while busy.
- R9: irq_o is high whenever any of status bits 9..7 is set together with the matching enable bit.
- R10: Reads of the enable word return it in bits 9..7. Reads of any other non-status index return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| slow_clk_i | input | 1 | Low-power domain clock |
| bus_we_i | input | 1 | Bus write strobe |
| bus_re_i | input | 1 | Bus read strobe |
| bus_addr_i | input | ADDR_W | Word index |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid the cycle after bus_re_i |
| irq_o | output | 1 | Combined flag interrupt |
| commit_valid_o | output | 1 | One slow-cycle pulse per committed write |
| commit_addr_o | output | ADDR_W | Committed word index |
| commit_data_o | output | DATA_W | Committed data |

## Verification
The handshake can return its acknowledge in the same bus cycle as a status read, so the complete flag can be set and cleared in one cycle. To provoke this, the bench holds the read strobe on the status word for every cycle across an entire transfer, which guarantees that one read coincides with the completion. The check passes only if exactly one of those reads returns the complete flag set and the last read shows the flag cleared. A design in which the clear wins would lose the completion and never show the flag.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  localparam int unsigned BIT_BUSY = 10;
  localparam int unsigned BIT_NEXT = 9;
  localparam int unsigned BIT_DONE = 8;
  localparam int unsigned BIT_ERR  = 7;
  localparam int unsigned FLAG_N   = 3;  // flags that can raise an interrupt
endpackage

// File: rtl/wsync_sync.sv
module wsync_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else begin
      ff_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/wsync_slow_commit.sv
module wsync_slow_commit #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [ADDR_W-1:0] hold_addr_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              ack_tgl_o,
  output logic              commit_valid_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o
);
  logic req_s, seen_q, new_req;

  wsync_sync #(.STAGES(STAGES)) i_req_sync (
    .clk_i (slow_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_i),
    .q_o   (req_s)
  );

  assign new_req = req_s ^ seen_q;

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q         <= 1'b0;
      commit_valid_o <= 1'b0;
      commit_addr_o  <= '0;
      commit_data_o  <= '0;
    end else begin
      seen_q         <= req_s;
      commit_valid_o <= new_req;
      if (new_req) begin
        commit_addr_o <= hold_addr_i;
        commit_data_o <= hold_data_i;
      end
    end
  end

  // acknowledge toggles together with the commit
  assign ack_tgl_o = seen_q;

  assert_commit_pulse_R2: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    commit_valid_o |=> !commit_valid_o);
endmodule

// File: rtl/wsync_bus_regs.sv
module wsync_bus_regs
  import wsync_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAT_IDX = 0,
  parameter int unsigned IEN_IDX  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              ack_s_i,
  output logic              req_tgl_o,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic [DATA_W-1:0] hold_data_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_IDX);
  localparam logic [ADDR_W-1:0] IEN_A  = ADDR_W'(IEN_IDX);

  logic busy_q, done_q, err_q;
  logic [FLAG_N-1:0] ien_q;
  logic is_stat, is_ien, sync_wr, accept, collide, ack_in;
  logic [FLAG_N-1:0] flags;
  logic [DATA_W-1:0] stat_word, ien_word;

  assign is_stat = bus_addr_i == STAT_A;
  assign is_ien  = bus_addr_i == IEN_A;
  assign sync_wr = bus_we_i && !is_stat && !is_ien;
  assign accept  = sync_wr && !busy_q;
  assign collide = sync_wr && busy_q;
  assign ack_in  = busy_q && (ack_s_i == req_tgl_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_tgl_o   <= 1'b0;
      hold_addr_o <= '0;
      hold_data_o <= '0;
      busy_q      <= 1'b0;
    end else if (accept) begin
      req_tgl_o   <= ~req_tgl_o;
      hold_addr_o <= bus_addr_i;
      hold_data_o <= bus_wdata_i;
      busy_q      <= 1'b1;
    end else if (ack_in) begin
      busy_q      <= 1'b0;
    end
  end

  // completion wins over a read-clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    done_q <= 1'b0;
    else if (ack_in)                done_q <= 1'b1;
    else if (bus_re_i && is_stat)   done_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          err_q <= 1'b0;
    else if (collide)                                     err_q <= 1'b1;
    else if (bus_we_i && is_stat && bus_wdata_i[BIT_ERR]) err_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ien_q <= '0;
    else if (bus_we_i && is_ien) ien_q <= bus_wdata_i[BIT_NEXT:BIT_ERR];
  end

  assign flags = {!busy_q, done_q, err_q};

  always_comb begin
    stat_word = '0;
    stat_word[BIT_BUSY] = busy_q;
    stat_word[BIT_NEXT:BIT_ERR] = flags;
    ien_word = '0;
    ien_word[BIT_NEXT:BIT_ERR] = ien_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rdata_o <= '0;
    else if (bus_re_i) begin
      if (is_stat)     bus_rdata_o <= stat_word;
      else if (is_ien) bus_rdata_o <= ien_word;
      else             bus_rdata_o <= '0;
    end
  end

  assign irq_o = |(flags & ien_q);

  assert_accept_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(req_tgl_o) |-> !$past(busy_q));
  assert_hold_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_q) && busy_q) |-> ($stable(hold_addr_o) && $stable(hold_data_o)));
  assert_done_on_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $fell(busy_q));
  assert_err_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(sync_wr && busy_q));
  assert_ien_no_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && is_ien && !busy_q) |=> !busy_q);
endmodule

// File: rtl/slow_reg_write_sync.sv
module slow_reg_write_sync #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned STAGES   = 2,
  parameter int unsigned STAT_IDX = 0,
  parameter int unsigned IEN_IDX  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_clk_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              commit_valid_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [DATA_W-1:0] commit_data_o
);
  logic              req_tgl, ack_tgl, ack_s;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;

  wsync_bus_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_IDX(STAT_IDX), .IEN_IDX(IEN_IDX)
  ) i_bus_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_re_i   (bus_re_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .ack_s_i    (ack_s),
    .req_tgl_o  (req_tgl),
    .hold_addr_o(hold_addr),
    .hold_data_o(hold_data),
    .bus_rdata_o(bus_rdata_o),
    .irq_o      (irq_o)
  );

  wsync_sync #(.STAGES(STAGES)) i_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl),
    .q_o   (ack_s)
  );

  wsync_slow_commit #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES)
  ) i_slow_commit (
    .slow_clk_i    (slow_clk_i),
    .rst_ni        (rst_ni),
    .req_tgl_i     (req_tgl),
    .hold_addr_i   (hold_addr),
    .hold_data_i   (hold_data),
    .ack_tgl_o     (ack_tgl),
    .commit_valid_o(commit_valid_o),
    .commit_addr_o (commit_addr_o),
    .commit_data_o (commit_data_o)
  );
endmodule

// File: tb/test_slow_reg_write_sync.sv
module test_slow_reg_write_sync;
  localparam logic [3:0] STAT = 4'h0;
  localparam logic [3:0] IEN  = 4'h1;
  localparam logic [35:0] VECS [4] = '{
    {4'h2, 32'hA5A5_0001}, {4'h7, 32'h0000_FFFF},
    {4'hF, 32'hFFFF_FFFF}, {4'h3, 32'h0000_0000}};

  logic clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, cd;
  logic [3:0]  ca;
  logic irq, cv;
  int checks = 0, fails = 0, ccnt = 0;
  logic [3:0]  last_a = '0;
  logic [31:0] last_d = '0;

  always #5 clk = ~clk;
  always #80 slow_clk = ~slow_clk;

  slow_reg_write_sync i_slow_reg_write_sync (
    .clk_i(clk), .rst_ni(rst_n), .slow_clk_i(slow_clk),
    .bus_we_i(we), .bus_re_i(re), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq),
    .commit_valid_o(cv), .commit_addr_o(ca), .commit_data_o(cd));

  always @(negedge slow_clk) begin
    if (rst_n && cv) begin
      ccnt++;
      last_a = ca;
      last_d = cd;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic wait_idle(output logic [31:0] r);
    r = 32'h400;
    for (int n = 0; n < 80 && r[10]; n++) rd(STAT, r);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int c0, seen;
    repeat (20) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R10 reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    rd(STAT, r); chk("R1 status after reset", r, 32'h200);
    rd(IEN, r);  chk("R1 enable after reset", r, 32'h0);
    rd(4'h5, r); chk("R10 other index reads zero", r, 32'h0);

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < 4; v++) begin
      logic [3:0]  va;
      logic [31:0] vd;
      int n;
      va = VECS[v][35:32];
      vd = VECS[v][31:0];
      c0 = ccnt;
      wr(va, vd);
      rd(STAT, r); chk("R3 busy after accept", r, 32'h400);
      n = 0;
      while (ccnt == c0 && n < 66) begin @(negedge clk); n++; end
      chk("R2 commit within four slow cycles", 32'(ccnt), 32'(c0 + 1));
      chk("R2 commit address", 32'(last_a), 32'(va));
      chk("R2 commit data", last_d, vd);
      wait_idle(r);
      chk("R4 done with busy release", r, 32'h300);
      rd(STAT, r); chk("R5 read clears done", r, 32'h200);
      chk("R2 single commit", 32'(ccnt), 32'(c0 + 1));
    end

    // R6 / R7 overlap error and its clearing
    c0 = ccnt;
    wr(4'h2, 32'h1111_2222);
    wr(4'h3, 32'h3333_4444);
    rd(STAT, r); chk("R6 error on overlapping write", r, 32'h480);
    wait_idle(r);
    repeat (70) @(negedge clk);
    chk("R6 dropped write not committed", 32'(ccnt), 32'(c0 + 1));
    chk("R6 first write committed", last_d, 32'h1111_2222);
    rd(STAT, r); chk("R7 read keeps error", r, 32'h280);
    wr(STAT, 32'h0000_0100);
    rd(STAT, r); chk("R7 write without bit7 keeps error", r, 32'h280);
    wr(STAT, 32'h0000_0080);
    rd(STAT, r); chk("R7 write one clears error", r, 32'h200);
    chk("R7 status write not synchronized", 32'(ccnt), 32'(c0 + 1));

    // R8 / R10 enable word
    c0 = ccnt;
    wr(IEN, 32'h0000_0100);
    rd(STAT, r); chk("R8 enable write sets no flag", r, 32'h200);
    rd(IEN, r);  chk("R10 enable readback", r, 32'h100);
    repeat (70) @(negedge clk);
    chk("R8 enable write not committed", 32'(ccnt), 32'(c0));
    wr(4'h4, 32'hCAFE_0004);
    wr(IEN, 32'h0000_0180);
    rd(STAT, r); chk("R8 enable write while busy no error", r, 32'h400);

    // R9 interrupt
    chk("R9 irq low while busy", 32'(irq), 32'h0);
    for (int n = 0; n < 150 && !irq; n++) @(negedge clk);
    chk("R9 irq on completion", 32'(irq), 32'h1);
    rd(STAT, r); chk("R9 status at irq", r, 32'h300);
    chk("R9 irq drops after read", 32'(irq), 32'h0);
    wr(IEN, 32'h0000_0200);
    chk("R9 irq from next flag", 32'(irq), 32'h1);
    wr(IEN, 32'h0000_0000);
    chk("R9 irq masked", 32'(irq), 32'h0);

    // R5 completion colliding with a read
    c0 = ccnt;
    wr(4'h6, 32'h0BAD_F00D);
    re = 1'b1; addr = STAT;
    seen = 0;
    repeat (150) begin
      @(negedge clk);
      if (rdata[8]) seen++;
    end
    re = 1'b0;
    chk("R5 completion seen exactly once under reads", 32'(seen), 32'h1);
    chk("R5 flag cleared at end", rdata, 32'h200);
    chk("R2 collision write committed", last_d, 32'h0BAD_F00D);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule